// File: doc/BRIEF.md
# Look-aside cache read arbiter

This block sits on a processor read path where the cache and main memory are looked up side by side. Each accepted read goes out to the cache tag lookup and to the memory port in the same cycle. The cache answers one cycle later. On a hit, the block returns the cached word and sends an abort to memory in that same cycle. On a miss, the memory access carries on. The word memory returns goes to the processor, and the block also writes it back into the cache through a fill port.

Only one read is in flight at a time. Each memory request carries a one-bit tag that alternates from one request to the next. Memory data with a stale tag, which can come back from an aborted request, is dropped. Two saturating counters record how many lookups hit and how many missed. A synchronous clear input resets both.

The request and response sides are valid/ready streams. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. A response stays presented, with its data held, until the cycle where `rsp_ready` is high. The cache and memory pins are plain strobes and carry no back-pressure.

Top module: `lookaside_rd_arb`

## Requirements
- R1: An accepted request raises `lk_valid` and `mem_req` together in the acceptance cycle, and both `lk_addr` and `mem_addr` equal `req_addr` in that cycle; neither strobe is high in any other cycle.
- R2: If `lk_hit` is high in the cycle after acceptance, `mem_abort` is high in that cycle, and the response carries `lk_data` from that cycle.
- R3: If `lk_hit` is low in the cycle after acceptance, `mem_abort` stays low, and the response carries `mem_rdata` from the first cycle (that cycle or later) where `mem_rvalid` is high with a matching tag.
- R4: The cycle after miss data is accepted from memory, `fill_valid` pulses for one cycle with `fill_addr` set to the request address and `fill_data` set to that data.
- R5: Memory data is ignored, with no response and no fill, when its tag does not match, when it arrives in the lookup cycle of a hit, or when no miss is waiting.
- R6: `mem_tag` is 0 on the first request after reset and alternates 0/1 on each later request; returned data matches when `mem_rtag` equals the tag of the outstanding request.
- R7: `req_ready` is high only when no read is outstanding, so it is low from the cycle after acceptance until the cycle after the response handshake.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values in the next cycle.
- R9: `hit_count` and `miss_count` each rise by one for every hit and every miss lookup result, and they saturate at all ones.
- R10: While `cnt_clear` is high, both counters read zero in the next cycle, even if a lookup result falls in the same cycle.
- R11: After reset, `req_ready` is 1, and `rsp_valid`, `lk_valid`, `mem_req`, `mem_abort`, `fill_valid` and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Arbiter can accept a read |
| req_addr | input | AW | Read address |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Requester takes the data |
| rsp_data | output | DW | Read data |
| lk_valid | output | 1 | Cache lookup strobe |
| lk_addr | output | AW | Cache lookup address |
| lk_hit | input | 1 | Lookup hit, valid the cycle after the strobe |
| lk_data | input | DW | Cached word, valid with lk_hit |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_tag | output | 1 | Tag of this memory request |
| mem_abort | output | 1 | Cancel the outstanding memory request |
| mem_rvalid | input | 1 | Memory data valid |
| mem_rtag | input | 1 | Tag of returned data |
| mem_rdata | input | DW | Returned memory word |
| fill_valid | output | 1 | Cache fill strobe |
| fill_addr | output | AW | Cache fill address |
| fill_data | output | DW | Cache fill word |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| hit_count | output | CNT_W | Saturating hit count |
| miss_count | output | CNT_W | Saturating miss count |

## Verification
Several rules are checked by assertions on every cycle. An abort only ever follows a request by one cycle. Lookup and memory strobes last a single cycle. An abort is never followed by a fill. A stalled response holds steady. A clear zeroes the counters. Full counters only stay full or clear. Other behaviour can only be shown by the bench's scenarios. That includes returning the right source's data, dropping stale or mistimed memory returns (including data that arrives in the same cycle as a hit), alternating tags when an aborted return lands during a later miss, a clear winning over a same-cycle lookup, and counters saturating after a long run of hits.

// File: rtl/lar_pkg.sv
package lar_pkg;
  typedef enum logic [1:0] {
    LAR_IDLE = 2'd0,
    LAR_LOOK = 2'd1,
    LAR_WAIT = 2'd2,
    LAR_RESP = 2'd3
  } lar_state_e;

  localparam int unsigned LAR_NUM_CNT = 2;
  localparam int unsigned LAR_CNT_HIT = 0;
  localparam int unsigned LAR_CNT_MISS = 1;
endpackage

// File: rtl/lar_ctrl.sv
module lar_ctrl
  import lar_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          issue,
  output logic          issue_tag,
  input  logic          lk_hit,
  input  logic [DW-1:0] lk_data,
  output logic          abort,
  input  logic          mem_rvalid,
  input  logic          mem_rtag,
  input  logic [DW-1:0] mem_rdata,
  output logic          cap,
  output logic [AW-1:0] cur_addr,
  output logic          hit_evt,
  output logic          miss_evt
);
  lar_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, data_d;
  logic          tag_q;
  logic          accept;
  logic          tag_match;

  assign req_ready = (state_q == LAR_IDLE);
  assign accept    = req_valid && req_ready;
  assign issue     = accept;
  assign issue_tag = ~tag_q;
  assign tag_match = mem_rvalid && (mem_rtag == tag_q);
  assign rsp_valid = (state_q == LAR_RESP);
  assign rsp_data  = data_q;
  assign cur_addr  = addr_q;

  always_comb begin
    state_d  = state_q;
    data_d   = data_q;
    abort    = 1'b0;
    cap      = 1'b0;
    hit_evt  = 1'b0;
    miss_evt = 1'b0;
    unique case (state_q)
      LAR_IDLE: if (accept) state_d = LAR_LOOK;
      LAR_LOOK: begin
        if (lk_hit) begin
          abort   = 1'b1;
          hit_evt = 1'b1;
          data_d  = lk_data;
          state_d = LAR_RESP;
        end else begin
          miss_evt = 1'b1;
          if (tag_match) begin
            cap     = 1'b1;
            data_d  = mem_rdata;
            state_d = LAR_RESP;
          end else begin
            state_d = LAR_WAIT;
          end
        end
      end
      LAR_WAIT: begin
        if (tag_match) begin
          cap     = 1'b1;
          data_d  = mem_rdata;
          state_d = LAR_RESP;
        end
      end
      LAR_RESP: if (rsp_ready) state_d = LAR_IDLE;
      default:  state_d = LAR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LAR_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      tag_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      data_q  <= data_d;
      if (accept) begin
        addr_q <= req_addr;
        tag_q  <= ~tag_q;
      end
    end
  end

  // R8: a stalled response keeps its data
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R7: no second acceptance right after one
  p_single_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3: capture of memory data never coincides with a hit outcome
  p_no_cap_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> !lk_hit || (state_q == LAR_WAIT));
endmodule

// File: rtl/lar_fill.sv
module lar_fill #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  output logic          fill_valid,
  output logic [AW-1:0] fill_addr,
  output logic [DW-1:0] fill_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_valid <= 1'b0;
      fill_addr  <= '0;
      fill_data  <= '0;
    end else begin
      fill_valid <= cap;
      if (cap) begin
        fill_addr <= cap_addr;
        fill_data <= cap_data;
      end
    end
  end

  // R4: a fill is a single-cycle pulse
  p_fill_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);
endmodule

// File: rtl/lar_sat_cnt.sv
module lar_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                 q <= '0;
    else if (clr)               q <= '0;
    else if (inc && (q != MAX)) q <= q + 1'b1;
  end

  // R10: clear wins and zeroes the count
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  // R9: a full counter stays full unless cleared
  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q == MAX && !clr) |=> (q == MAX));
endmodule

// File: rtl/lookaside_rd_arb.sv
module lookaside_rd_arb
  import lar_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  output logic             lk_valid,
  output logic [AW-1:0]    lk_addr,
  input  logic             lk_hit,
  input  logic [DW-1:0]    lk_data,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_tag,
  output logic             mem_abort,
  input  logic             mem_rvalid,
  input  logic             mem_rtag,
  input  logic [DW-1:0]    mem_rdata,
  output logic             fill_valid,
  output logic [AW-1:0]    fill_addr,
  output logic [DW-1:0]    fill_data,
  input  logic             cnt_clear,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  logic                              issue;
  logic                              cap;
  logic [AW-1:0]                     cur_addr;
  logic                              hit_evt, miss_evt;
  logic [LAR_NUM_CNT-1:0]            cnt_inc;
  logic [LAR_NUM_CNT-1:0][CNT_W-1:0] cnt_val;

  lar_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .issue      (issue),
    .issue_tag  (mem_tag),
    .lk_hit     (lk_hit),
    .lk_data    (lk_data),
    .abort      (mem_abort),
    .mem_rvalid (mem_rvalid),
    .mem_rtag   (mem_rtag),
    .mem_rdata  (mem_rdata),
    .cap        (cap),
    .cur_addr   (cur_addr),
    .hit_evt    (hit_evt),
    .miss_evt   (miss_evt)
  );

  assign lk_valid = issue;
  assign lk_addr  = req_addr;
  assign mem_req  = issue;
  assign mem_addr = req_addr;

  lar_fill #(.AW(AW), .DW(DW)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap        (cap),
    .cap_addr   (cur_addr),
    .cap_data   (mem_rdata),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr),
    .fill_data  (fill_data)
  );

  assign cnt_inc[LAR_CNT_HIT]  = hit_evt;
  assign cnt_inc[LAR_CNT_MISS] = miss_evt;

  for (genvar g = 0; g < LAR_NUM_CNT; g++) begin : g_cnt
    lar_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clear),
      .inc   (cnt_inc[g]),
      .q     (cnt_val[g])
    );
  end

  assign hit_count  = cnt_val[LAR_CNT_HIT];
  assign miss_count = cnt_val[LAR_CNT_MISS];

  // R2: an abort only follows a request by exactly one cycle
  p_abort_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_abort |-> $past(mem_req));

  // R1: lookup and memory strobes are single-cycle
  p_issue_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (!mem_req && !lk_valid));

  // R5: an aborted request never produces a fill
  p_no_fill_after_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_abort |=> !fill_valid);
endmodule

// File: tb/tb_lookaside_rd_arb.sv
`timescale 1ns/1ps
module tb_lookaside_rd_arb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CNT_W = 4;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic lk_valid;
  logic [AW-1:0] lk_addr;
  logic lk_hit = 1'b0;
  logic [DW-1:0] lk_data = '0;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic mem_tag;
  logic mem_abort;
  logic mem_rvalid = 1'b0;
  logic mem_rtag = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic fill_valid;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data;
  logic cnt_clear = 1'b0;
  logic [CNT_W-1:0] hit_count, miss_count;

  always #4 clk = ~clk;

  lookaside_rd_arb #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] rsp_q[$];
  logic [AW+DW-1:0] fill_q[$];
  bit next_hit = 1'b0;
  int mem_lat = 3;
  bit stale_mode = 1'b0;
  bit rdy_mode = 1'b0;
  int exp_hit = 0;
  int exp_miss = 0;
  bit busy = 1'b0;
  logic exp_tag = 1'b0;
  logic [AW-1:0] drv_addr = '0;
  bit cpend = 1'b0;
  bit chit = 1'b0;
  logic [AW-1:0] caddr = '0;
  bit hold_chk = 1'b0;
  logic [DW-1:0] held = '0;
  int cyc = 0;

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return {a, a} ^ 32'h1234_5678;
  endfunction

  function automatic logic [DW-1:0] cache_fn(input logic [AW-1:0] a);
    return ~mem_fn(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // ready pattern for back-pressure
  initial forever begin
    @(negedge clk);
    cyc++;
    rsp_ready = rdy_mode ? ((cyc % 3) == 0) : 1'b1;
  end

  // cache model: answers the cycle after the lookup strobe
  initial forever begin
    @(negedge clk);
    if (cpend) begin
      lk_hit  = chit;
      lk_data = cache_fn(caddr);
    end else begin
      lk_hit  = 1'b0;
      lk_data = '0;
    end
    #2;
    if (cpend) begin
      if (chit) chk(mem_abort == 1'b1, "R2 abort on hit", mem_abort, 1);
      else      chk(mem_abort == 1'b0, "R3 no abort on miss", mem_abort, 0);
    end
    cpend = lk_valid;
    if (lk_valid) begin
      caddr = lk_addr;
      chit  = next_hit;
    end
  end

  task automatic mem_thread(input logic [AW-1:0] a, input logic t, input int lat);
    bit ab = 1'b0;
    bit sent = 1'b0;
    for (int i = 1; i < lat; i++) begin
      @(negedge clk);
      #2;
      if (mem_abort) ab = 1'b1;
    end
    @(negedge clk);
    if (!ab || stale_mode) begin
      mem_rvalid = 1'b1;
      mem_rtag   = t;
      mem_rdata  = mem_fn(a);
      sent = 1'b1;
    end
    @(negedge clk);
    if (sent) mem_rvalid = 1'b0;
  endtask

  // memory model: fixed latency per phase, honours abort unless stale_mode
  initial forever begin
    @(negedge clk);
    #2;
    if (mem_req) begin
      chk(lk_valid && lk_addr == drv_addr && mem_addr == drv_addr, "R1 parallel issue",
          {lk_valid, lk_addr, mem_addr}, {1'b1, drv_addr, drv_addr});
      chk(mem_tag == exp_tag, "R6 tag sequence", mem_tag, exp_tag);
      exp_tag = ~exp_tag;
      begin
        automatic logic [AW-1:0] a = mem_addr;
        automatic logic t = mem_tag;
        automatic int l = mem_lat;
        fork
          mem_thread(a, t, l);
        join_none
      end
    end
  end

  // monitor: scoreboard for responses and fills
  initial forever begin
    @(negedge clk);
    #2;
    if (!rst_n) continue;
    if (hold_chk)
      chk(rsp_valid && rsp_data == held, "R8 response hold", rsp_data, held);
    hold_chk = rsp_valid && !rsp_ready;
    held     = rsp_data;
    if (busy)
      chk(!req_ready, "R7 one outstanding", req_ready, 0);
    if (rsp_valid && rsp_ready) begin
      if (rsp_q.size() == 0) chk(1'b0, "R5 unexpected response", rsp_data, 0);
      else begin
        automatic logic [DW-1:0] e = rsp_q.pop_front();
        chk(rsp_data == e, "R2/R3 response data", rsp_data, e);
      end
      busy = 1'b0;
    end
    if (req_valid && req_ready) busy = 1'b1;
    if (fill_valid) begin
      if (fill_q.size() == 0) chk(1'b0, "R5 unexpected fill", {fill_addr, fill_data}, 0);
      else begin
        automatic logic [AW+DW-1:0] f = fill_q.pop_front();
        chk({fill_addr, fill_data} == f, "R4 fill", {fill_addr, fill_data}, f);
      end
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input bit hit, input bit count = 1'b1);
    @(negedge clk);
    next_hit  = hit;
    req_valid = 1'b1;
    req_addr  = a;
    drv_addr  = a;
    rsp_q.push_back(hit ? cache_fn(a) : mem_fn(a));
    if (!hit) fill_q.push_back({a, mem_fn(a)});
    if (count) begin
      if (hit) exp_hit++;
      else     exp_miss++;
    end
    #2;
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (rsp_q.size() != 0 || fill_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic chk_counts(input string tag);
    automatic int eh = (exp_hit > CMAX) ? CMAX : exp_hit;
    automatic int em = (exp_miss > CMAX) ? CMAX : exp_miss;
    @(negedge clk);
    #2;
    chk(hit_count == eh[CNT_W-1:0], tag, hit_count, eh);
    chk(miss_count == em[CNT_W-1:0], tag, miss_count, em);
  endtask

  task automatic do_clear();
    @(negedge clk);
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    exp_hit = 0;
    exp_miss = 0;
    #2;
    chk(hit_count == 0 && miss_count == 0, "R10 clear", {hit_count, miss_count}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R11: reset state
    chk(req_ready == 1'b1, "R11 req_ready", req_ready, 1);
    chk({rsp_valid, lk_valid, mem_req, mem_abort, fill_valid} == 5'b0, "R11 strobes",
        {rsp_valid, lk_valid, mem_req, mem_abort, fill_valid}, 0);
    chk(hit_count == 0 && miss_count == 0, "R11 counters", {hit_count, miss_count}, 0);

    // mixed hits and misses, memory latency 3
    mem_lat = 3;
    for (int i = 0; i < 8; i++) do_read(16'h0100 + 16'(i * 7), (i % 3) == 0);
    drain();
    chk_counts("R9 mixed counts");

    // memory data arrives in the lookup cycle (R3 fast miss, R5 hit ignores it)
    mem_lat = 1;
    for (int i = 0; i < 6; i++) do_read(16'h2200 + 16'(i), (i % 2) == 1);
    drain();
    chk_counts("R9 fast memory counts");

    // aborted requests still return stale data with an old tag (R5, R6)
    stale_mode = 1'b1;
    mem_lat = 5;
    for (int i = 0; i < 8; i++) do_read(16'h3300 + 16'(i * 3), (i % 2) == 0);
    drain();
    stale_mode = 1'b0;
    chk_counts("R9 stale counts");

    // response back-pressure (R8)
    rdy_mode = 1'b1;
    mem_lat = 2;
    for (int i = 0; i < 6; i++) do_read(16'h4400 + 16'(i * 5), (i % 3) == 1);
    drain();
    rdy_mode = 1'b0;
    chk_counts("R9 back-pressure counts");

    // R10: clear, then clear colliding with a lookup result
    do_clear();
    do_read(16'h5555, 1'b1, 1'b0);
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    #2;
    chk(hit_count == 0 && miss_count == 0, "R10 clear priority", {hit_count, miss_count}, 0);
    drain();

    // R9: saturation after many hits
    mem_lat = 2;
    for (int i = 0; i < 20; i++) do_read(16'h6000 + 16'(i), 1'b1);
    do_read(16'h6100, 1'b0);
    drain();
    chk_counts("R9 saturation");

    finish_run();
  end
endmodule